// File: doc/BRIEF.md
# Interlaced Composite Raster Timing Generator

This block derives every raster timing signal for an interlaced, broadcast-style display from a single pixel-rate clock. A horizontal counter steps through a 228-clock line. A line counter steps through a field whose length alternates: 263 lines in the odd field and 262 lines in the even field. From these two counters the block decodes composite sync, a colour-burst gate, horizontal blank, vertical blank, a field flag and a per-line toggle.

At the top of each field the block runs a vertical interval made of half-line slots. First come six equalization half-lines, with two narrow sync pulses per line. Next come six serration half-lines, where sync is inverted and carries narrow low notches. Last come six more equalization half-lines. The interval starts at mid-line (cycle 114 of line 0) in the odd field and at cycle 0 of line 0 in the even field. Because of this, successive vertical intervals are always 262.5 lines apart. All outputs are decoded from registered counter state, and a synchronous active-low reset restarts the raster.

Top module: `ilace_vtiming`

## Requirements
- R1: A line is 228 clocks long (cycles 0..227). `line_tgl` changes value exactly when the cycle count wraps from 227 to 0.
- R2: On a normal line, `csync` is high on cycles 0..17 and low on all other cycles.
- R3: `hblank` is high on cycles 222..227 and 0..32 of every line and low on cycles 33..221.
- R4: `burst` is high on cycles 21..29 of every line, except on the first 9 lines whose first half lies inside the vertical interval of the field; on those lines it stays low. At all other cycles it is low.
- R5: In an equalization half-line, `csync` is high for the first 9 clocks of the half-line (cycles 0..8 or 114..122) and low for the rest.
- R6: In a serration half-line, `csync` is low on the last 9 clocks of the half-line (cycles 105..113 or 219..227) and high for the rest.
- R7: The odd field (`field` = 0) lasts 263 lines and the even field (`field` = 1) lasts 262 lines. `field` toggles only at the wrap from the last cycle of the last line.
- R8: The vertical interval is 18 half-lines long, in the order 6 equalization, 6 serration, 6 equalization. It starts at line 0, cycle 114 in the odd field and at line 0, cycle 0 in the even field. Outside the interval, lines are normal.
- R9: `vblank` is high for 42 half-lines (21 lines), starting at the start of the vertical interval, and low for the rest of the field.
- R10: While `rst_n` is low at a rising clock edge, the block goes to line 0, cycle 0 of the odd field. In that state the outputs are `csync`=1, `hblank`=1, `burst`=0, `vblank`=0, `field`=0 and `line_tgl`=0. After reset is released, each rising edge advances the raster by one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| csync | output | 1 | Composite sync, high = sync tip |
| burst | output | 1 | Colour-burst gate |
| hblank | output | 1 | Horizontal blank |
| vblank | output | 1 | Vertical blank |
| field | output | 1 | Field flag, 0 = odd (263 lines), 1 = even (262 lines) |
| line_tgl | output | 1 | Changes value at the start of every line |

## Verification
The bench builds the block with its default parameters: a 228-clock line and fields of 263 and 262 lines. With these values two full fields take under 120,000 cycles, so both interval phases fall inside one run. These phases are the mid-line start in the odd field and the line-start start in the even field. The run also covers both field wraps and the return to the odd field. Spot vectors sit on every edge of the sync, burst and blanking windows, and on both edges of the serration notches and equalization pulses. A reset applied in mid-raster then confirms the restart state.

// File: rtl/vt_pkg.sv
`timescale 1ns/1ps
package vt_pkg;
  typedef enum logic [1:0] {
    SEG_NORMAL = 2'd0,
    SEG_EQUAL  = 2'd1,
    SEG_SERR   = 2'd2
  } seg_e;
endpackage

// File: rtl/vt_hcount.sv
`timescale 1ns/1ps
module vt_hcount #(
  parameter int LINE_CLKS = 228,
  localparam int HW = $clog2(LINE_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] hcnt,
  output logic          h_last,
  output logic          h_upper
);
  localparam logic [HW-1:0] LAST_C = HW'(LINE_CLKS - 1);
  localparam logic [HW-1:0] HALF_C = HW'(LINE_CLKS / 2);

  always_ff @(posedge clk) begin
    if (!rst_n)      hcnt <= '0;
    else if (h_last) hcnt <= '0;
    else             hcnt <= hcnt + 1'b1;
  end

  assign h_last  = (hcnt == LAST_C);
  assign h_upper = (hcnt >= HALF_C);

  AST_HCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !h_last |=> hcnt == HW'($past(hcnt) + 1'b1)); // R1
  AST_HCNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    h_last |=> hcnt == '0); // R1
endmodule

// File: rtl/vt_vcount.sv
`timescale 1ns/1ps
module vt_vcount #(
  parameter int LONG_LINES  = 263,
  parameter int SHORT_LINES = 262,
  localparam int LW = $clog2(LONG_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_last,
  output logic [LW-1:0] line,
  output logic          field,
  output logic          line_tgl
);
  localparam logic [LW-1:0] LONG_LAST  = LW'(LONG_LINES - 1);
  localparam logic [LW-1:0] SHORT_LAST = LW'(SHORT_LINES - 1);

  logic line_last;
  assign line_last = field ? (line == SHORT_LAST) : (line == LONG_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line     <= '0;
      field    <= 1'b0;
      line_tgl <= 1'b0;
    end else if (h_last) begin
      line_tgl <= ~line_tgl;
      if (line_last) begin
        line  <= '0;
        field <= ~field;
      end else begin
        line <= line + 1'b1;
      end
    end
  end

  AST_FIELD_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (h_last && line_last) |=> field != $past(field)); // R7
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_last && line_last) |=> $stable(field)); // R7
  AST_LINE_TGL: assert property (@(posedge clk) disable iff (!rst_n)
    h_last |=> line_tgl != $past(line_tgl)); // R1
endmodule

// File: rtl/vt_vdecode.sv
`timescale 1ns/1ps
module vt_vdecode
  import vt_pkg::*;
#(
  parameter int LW              = 9,
  parameter int EQ_PRE_LINES    = 3,
  parameter int SERR_LINES      = 3,
  parameter int EQ_POST_LINES   = 3,
  parameter int VBL_LINES       = 21,
  parameter int BURST_OFF_LINES = 9,
  localparam int VW = LW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] line,
  input  logic          h_upper,
  input  logic          field,
  output seg_e          seg,
  output logic          vblank,
  output logic          burst_ok
);
  localparam logic [VW-1:0] EQ1_END = VW'(2 * EQ_PRE_LINES);
  localparam logic [VW-1:0] SRR_END = VW'(2 * (EQ_PRE_LINES + SERR_LINES));
  localparam logic [VW-1:0] INT_END = VW'(2 * (EQ_PRE_LINES + SERR_LINES + EQ_POST_LINES));
  localparam logic [VW-1:0] VBL_END = VW'(2 * VBL_LINES);
  localparam logic [VW-1:0] BOF_END = VW'(2 * BURST_OFF_LINES);

  logic [VW-1:0] abs_half, shift, rel;
  logic          started;

  // The odd field starts its interval half a line later than the even field.
  assign abs_half = {line, h_upper};
  assign shift    = field ? '0 : VW'(1);
  assign started  = (abs_half >= shift);
  assign rel      = abs_half - shift;

  always_comb begin
    seg = SEG_NORMAL;
    if (started) begin
      if (rel < EQ1_END)      seg = SEG_EQUAL;
      else if (rel < SRR_END) seg = SEG_SERR;
      else if (rel < INT_END) seg = SEG_EQUAL;
    end
  end

  assign vblank   = started && (rel < VBL_END);
  assign burst_ok = !(started && (rel < BOF_END));

  AST_VBL_COVERS_INT: assert property (@(posedge clk) disable iff (!rst_n)
    (seg != SEG_NORMAL) |-> vblank); // R9
  AST_NO_BURST_IN_INT: assert property (@(posedge clk) disable iff (!rst_n)
    (seg != SEG_NORMAL) |-> !burst_ok); // R4
endmodule

// File: rtl/vt_hdecode.sv
`timescale 1ns/1ps
module vt_hdecode
  import vt_pkg::*;
#(
  parameter int LINE_CLKS   = 228,
  parameter int HSYNC_CLKS  = 18,
  parameter int EQ_CLKS     = 9,
  parameter int SERR_CLKS   = 9,
  parameter int BURST_FIRST = 21,
  parameter int BURST_CLKS  = 9,
  parameter int HBL_FIRST   = 222,
  parameter int HBL_LAST    = 32,
  localparam int HW = $clog2(LINE_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hcnt,
  input  seg_e          seg,
  output logic          csync,
  output logic          burst_win,
  output logic          hblank
);
  localparam int HALF = LINE_CLKS / 2;
  localparam logic [HW-1:0] HALF_C = HW'(HALF);
  localparam logic [HW-1:0] HS_END = HW'(HSYNC_CLKS);
  localparam logic [HW-1:0] EQ_END = HW'(EQ_CLKS);
  localparam logic [HW-1:0] SR_BEG = HW'(HALF - SERR_CLKS);
  localparam logic [HW-1:0] B_LO   = HW'(BURST_FIRST);
  localparam logic [HW-1:0] B_HI   = HW'(BURST_FIRST + BURST_CLKS - 1);
  localparam logic [HW-1:0] HB_LO  = HW'(HBL_FIRST);
  localparam logic [HW-1:0] HB_HI  = HW'(HBL_LAST);

  logic [HW-1:0] pos;
  assign pos = (hcnt >= HALF_C) ? (hcnt - HALF_C) : hcnt;

  always_comb begin
    unique case (seg)
      SEG_EQUAL: csync = (pos < EQ_END);
      SEG_SERR:  csync = (pos < SR_BEG);
      default:   csync = (hcnt < HS_END);
    endcase
  end

  assign burst_win = (hcnt >= B_LO) && (hcnt <= B_HI);
  assign hblank    = (hcnt >= HB_LO) || (hcnt <= HB_HI);

  AST_BURST_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    burst_win |-> hblank); // R3
  AST_SERR_NOTCH: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == SEG_SERR && pos >= SR_BEG) |-> !csync); // R6
endmodule

// File: rtl/ilace_vtiming.sv
`timescale 1ns/1ps
module ilace_vtiming
  import vt_pkg::*;
#(
  parameter int LINE_CLKS       = 228,
  parameter int LONG_LINES      = 263,
  parameter int SHORT_LINES     = 262,
  parameter int HSYNC_CLKS      = 18,
  parameter int EQ_CLKS         = 9,
  parameter int SERR_CLKS       = 9,
  parameter int BURST_FIRST     = 21,
  parameter int BURST_CLKS      = 9,
  parameter int HBL_FIRST       = 222,
  parameter int HBL_LAST        = 32,
  parameter int EQ_PRE_LINES    = 3,
  parameter int SERR_LINES      = 3,
  parameter int EQ_POST_LINES   = 3,
  parameter int VBL_LINES       = 21,
  parameter int BURST_OFF_LINES = 9
) (
  input  logic clk,
  input  logic rst_n,
  output logic csync,
  output logic burst,
  output logic hblank,
  output logic vblank,
  output logic field,
  output logic line_tgl
);
  localparam int HW = $clog2(LINE_CLKS);
  localparam int LW = $clog2(LONG_LINES);

  logic [HW-1:0] hcnt;
  logic          h_last, h_upper;
  logic [LW-1:0] line;
  seg_e          seg;
  logic          burst_ok, burst_win;

  vt_hcount #(.LINE_CLKS(LINE_CLKS)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .h_last(h_last), .h_upper(h_upper)
  );

  vt_vcount #(.LONG_LINES(LONG_LINES), .SHORT_LINES(SHORT_LINES)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .h_last(h_last),
    .line(line), .field(field), .line_tgl(line_tgl)
  );

  vt_vdecode #(
    .LW(LW), .EQ_PRE_LINES(EQ_PRE_LINES), .SERR_LINES(SERR_LINES),
    .EQ_POST_LINES(EQ_POST_LINES), .VBL_LINES(VBL_LINES),
    .BURST_OFF_LINES(BURST_OFF_LINES)
  ) u_vdec (
    .clk(clk), .rst_n(rst_n), .line(line), .h_upper(h_upper), .field(field),
    .seg(seg), .vblank(vblank), .burst_ok(burst_ok)
  );

  vt_hdecode #(
    .LINE_CLKS(LINE_CLKS), .HSYNC_CLKS(HSYNC_CLKS), .EQ_CLKS(EQ_CLKS),
    .SERR_CLKS(SERR_CLKS), .BURST_FIRST(BURST_FIRST), .BURST_CLKS(BURST_CLKS),
    .HBL_FIRST(HBL_FIRST), .HBL_LAST(HBL_LAST)
  ) u_hdec (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .seg(seg),
    .csync(csync), .burst_win(burst_win), .hblank(hblank)
  );

  assign burst = burst_win & burst_ok;

  AST_BURST_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !(burst && csync)); // R4
  AST_BURST_BLANKED: assert property (@(posedge clk) disable iff (!rst_n)
    burst |-> hblank); // R3
endmodule

// File: tb/ilace_vtiming_test.sv
`timescale 1ns/1ps
module ilace_vtiming_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;
  logic csync, burst, hblank, vblank, field, line_tgl;

  ilace_vtiming uut (
    .clk(clk), .rst_n(rst_n), .csync(csync), .burst(burst), .hblank(hblank),
    .vblank(vblank), .field(field), .line_tgl(line_tgl)
  );

  int unsigned tcnt;
  always @(posedge clk) begin
    if (!rst_n) tcnt <= 0;
    else        tcnt <= tcnt + 1;
  end

  int total = 0;
  int bad   = 0;

  // entry: {time since reset[19:0], requirement[3:0], {field,vblank,hblank,burst,csync}}
  localparam int NV = 37;
  localparam logic [28:0] VEC [NV] = '{
    {20'd0,      4'd2,  5'b00101},
    {20'd25,     4'd4,  5'b00110},
    {20'd114,    4'd8,  5'b01001},
    {20'd123,    4'd5,  5'b01000},
    {20'd227,    4'd1,  5'b01100},
    {20'd228,    4'd1,  5'b01101},
    {20'd253,    4'd4,  5'b01100},
    {20'd798,    4'd6,  5'b01001},
    {20'd962,    4'd6,  5'b01001},
    {20'd1017,   4'd6,  5'b01000},
    {20'd1367,   4'd6,  5'b01100},
    {20'd1482,   4'd5,  5'b01001},
    {20'd1568,   4'd5,  5'b01000},
    {20'd2052,   4'd5,  5'b01101},
    {20'd2077,   4'd4,  5'b01100},
    {20'd2166,   4'd8,  5'b01000},
    {20'd2305,   4'd4,  5'b01110},
    {20'd4901,   4'd9,  5'b01000},
    {20'd4902,   4'd9,  5'b00000},
    {20'd22817,  4'd2,  5'b00101},
    {20'd22818,  4'd2,  5'b00100},
    {20'd22820,  4'd4,  5'b00100},
    {20'd22821,  4'd4,  5'b00110},
    {20'd22829,  4'd4,  5'b00110},
    {20'd22830,  4'd4,  5'b00100},
    {20'd22832,  4'd3,  5'b00100},
    {20'd22833,  4'd3,  5'b00000},
    {20'd23021,  4'd3,  5'b00000},
    {20'd23022,  4'd3,  5'b00100},
    {20'd59963,  4'd7,  5'b00100},
    {20'd59964,  4'd7,  5'b11101},
    {20'd59989,  4'd4,  5'b11100},
    {20'd60078,  4'd5,  5'b11001},
    {20'd60753,  4'd6,  5'b11000},
    {20'd62015,  4'd5,  5'b11100},
    {20'd62041,  4'd4,  5'b11110},
    {20'd119700, 4'd7,  5'b00101}
  };

  function automatic string rname(input logic [3:0] r);
    case (r)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input int unsigned t, input logic [5:0] exp);
    logic [5:0] act;
    act = {field, vblank, hblank, burst, csync, line_tgl};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s t=%0d actual=%b expected=%b (field,vblank,hblank,burst,csync,line_tgl)",
               tag, t, act, exp);
    end
  endtask

  initial begin
    #(20ns * 200000);
    total++;
    bad++;
    $display("FAIL R1 watchdog expired at t=%0d actual=running expected=finished", tcnt);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10", 0, 6'b001010);          // reset state
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      int unsigned t;
      logic [5:0] exp;
      t = VEC[i][28:9];
      while (tcnt != t) @(negedge clk);
      exp = {VEC[i][4:0], 1'((t / 228) % 2)}; // R1: line_tgl flips each line
      check(rname(VEC[i][8:5]), t, exp);
    end

    // R10: reset in mid-raster returns to line 0, cycle 0, odd field
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10", 0, 6'b001010);
    @(negedge clk);
    check("R10", 0, 6'b001010);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", 1, 6'b001010);          // position 1 after release
    repeat (20) @(negedge clk);
    check("R4", 21, 6'b001100);          // burst opens on cycle 21 of odd line 0

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule